// File: doc/BRIEF.md
# CSR Access Control Decoder

This block sits beside the execute stage of a RISC-V style core and handles the six control-and-status-register instructions. These are read-write, read-set and read-clear, each in a register-operand form and an immediate form. For each valid instruction it decides whether the addressed register is actually read and whether it is actually written. It also computes the value to be written from the old register contents and the operand. It raises an illegal-instruction flag when a real write targets a read-only address.

Read and write enables, and the matching side-effect strobes, do not come from the opcode alone. They are suppressed by the zero-index rules on the destination index, the source index and the immediate field. A write that would only hand the register a value it already holds still counts as a write access. All decisions and data are registered and appear one clock after the instruction is presented. The register file, the CSR storage, privilege checks and trap entry lie outside the block.

Top module: `csr_access_ctl`

## Requirements
- R1: funct3 decodes as 001 read-write, 010 set, 011 clear, 101 immediate read-write, 110 immediate set, 111 immediate clear. For 000 and 100, csr_op_o, every enable, every strobe and illegal_o stay low.
- R2: Every output is registered and reflects the inputs sampled at the previous rising clock edge. While instr_valid_i is low, all outputs are zero on the next cycle, and all outputs are zero after reset.
- R3: The operand is the rs1 register value for register forms. For immediate forms it is the 5-bit rs1 index field zero-extended to XLEN.
- R4: wdata_o is the operand for read-write, old OR operand for set, and old AND NOT operand for clear. Bits outside the mask therefore keep their old value.
- R5: For register-form set and clear, an rs1 index of 0 suppresses wr_en_o, wr_fx_o and illegal_o. A nonzero index whose register holds zero still counts as a write.
- R6: For immediate set and clear, a uimm of 0 suppresses wr_en_o, wr_fx_o and illegal_o.
- R7: Set and clear, in both forms, always assert rd_en_o. They also assert rd_fx_o unless illegal_o is raised, whatever rd and rs1 hold.
- R8: Read-write, in both forms, with an rd index of 0 keeps rd_en_o and rd_fx_o low. Read-write always intends a write.
- R9: An address with bits [11:10] equal to 11 is read-only. A write intent to it raises illegal_o and holds wr_en_o, wr_fx_o and rd_fx_o low.
- R10: rd_data_o carries csr_rdata_i when rd_en_o is high, and zero otherwise.
- R11: wr_fx_o marks the write access alone. It fires for every performed write, even when wdata_o equals the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction fields are valid this cycle |
| funct3_i | input | 3 | Instruction funct3 field |
| rd_idx_i | input | IDX_W | Destination register index |
| rs1_idx_i | input | IDX_W | Source index, or uimm in immediate forms |
| rs1_val_i | input | XLEN | Source register value |
| csr_addr_i | input | ADDR_W | CSR address |
| csr_rdata_i | input | XLEN | Current CSR contents |
| csr_op_o | output | 1 | A CSR instruction was decoded |
| rd_en_o | output | 1 | CSR is read |
| wr_en_o | output | 1 | CSR is written |
| rd_fx_o | output | 1 | Read side-effect strobe |
| wr_fx_o | output | 1 | Write side-effect strobe |
| illegal_o | output | 1 | Write to a read-only CSR |
| wdata_o | output | XLEN | New CSR value |
| rd_data_o | output | XLEN | Value returned to rd |

## Verification
The bench builds the block with XLEN=16 and leaves the 5-bit index and 12-bit address widths at their defaults. With the narrower data width, random operands and old values often share bits or hit all-zero and all-ones masks. Set and clear results that leave the register unchanged therefore occur often, which exercises R11. Random addresses reach the read-only quarter about one time in four, and zero indices are forced often enough to cover every suppression rule.

// File: rtl/csr_ctl_pkg.sv
package csr_ctl_pkg;
  typedef enum logic [1:0] {
    CSR_NONE = 2'd0,
    CSR_RW   = 2'd1,
    CSR_SET  = 2'd2,
    CSR_CLR  = 2'd3
  } csr_kind_e;
endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
  import csr_ctl_pkg::*;
(
  input  logic [2:0] funct3_i,
  output csr_kind_e  kind_o,
  output logic       is_imm_o
);
  always_comb begin
    is_imm_o = funct3_i[2];
    unique case (funct3_i[1:0])
      2'b01:   kind_o = CSR_RW;
      2'b10:   kind_o = CSR_SET;
      2'b11:   kind_o = CSR_CLR;
      default: kind_o = CSR_NONE;
    endcase
  end
endmodule

// File: rtl/csr_access_gate.sv
module csr_access_gate
  import csr_ctl_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 12
) (
  input  csr_kind_e         kind_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [IDX_W-1:0]  rs1_idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              want_rd_o,
  output logic              want_wr_o,
  output logic              ro_o,
  output logic              illegal_o
);
  logic rd_nz, rs1_nz;
  assign rd_nz  = |rd_idx_i;
  assign rs1_nz = |rs1_idx_i;  // same field carries uimm in immediate forms

  always_comb begin
    unique case (kind_i)
      CSR_RW:          begin want_rd_o = rd_nz; want_wr_o = 1'b1;   end
      CSR_SET, CSR_CLR:begin want_rd_o = 1'b1;  want_wr_o = rs1_nz; end
      default:         begin want_rd_o = 1'b0;  want_wr_o = 1'b0;   end
    endcase
  end

  assign ro_o      = (addr_i[ADDR_W-1 -: 2] == 2'b11);
  assign illegal_o = want_wr_o & ro_o;

  always_comb begin
    if (kind_i == CSR_NONE)
      AST_NONE_IDLE: assert (!want_rd_o && !want_wr_o); // R1
  end
endmodule

// File: rtl/csr_value_calc.sv
module csr_value_calc
  import csr_ctl_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input  csr_kind_e        kind_i,
  input  logic             is_imm_i,
  input  logic [IDX_W-1:0] rs1_idx_i,
  input  logic [XLEN-1:0]  rs1_val_i,
  input  logic [XLEN-1:0]  old_i,
  output logic [XLEN-1:0]  new_o
);
  localparam int PAD_W = XLEN - IDX_W;

  logic [XLEN-1:0] operand;
  assign operand = is_imm_i ? {{PAD_W{1'b0}}, rs1_idx_i} : rs1_val_i;

  always_comb begin
    unique case (kind_i)
      CSR_RW:  new_o = operand;
      CSR_SET: new_o = old_i | operand;
      CSR_CLR: new_o = old_i & ~operand;
      default: new_o = '0;
    endcase
  end

  always_comb begin
    if (kind_i == CSR_SET)
      AST_SET_KEEPS_ONES: assert ((new_o & old_i) == old_i); // R4
    if (kind_i == CSR_CLR)
      AST_CLR_ADDS_NONE: assert ((new_o & ~old_i) == '0);   // R4
  end
endmodule

// File: rtl/csr_access_ctl.sv
module csr_access_ctl
  import csr_ctl_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [2:0]        funct3_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [IDX_W-1:0]  rs1_idx_i,
  input  logic [XLEN-1:0]   rs1_val_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [XLEN-1:0]   csr_rdata_i,
  output logic              csr_op_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic              rd_fx_o,
  output logic              wr_fx_o,
  output logic              illegal_o,
  output logic [XLEN-1:0]   wdata_o,
  output logic [XLEN-1:0]   rd_data_o
);
  csr_kind_e       kind;
  logic            is_imm, want_rd, want_wr, ro, illegal;
  logic [XLEN-1:0] new_val;

  csr_op_decode u_dec (
    .funct3_i (funct3_i),
    .kind_o   (kind),
    .is_imm_o (is_imm)
  );

  csr_access_gate #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_gate (
    .kind_i    (kind),
    .rd_idx_i  (rd_idx_i),
    .rs1_idx_i (rs1_idx_i),
    .addr_i    (csr_addr_i),
    .want_rd_o (want_rd),
    .want_wr_o (want_wr),
    .ro_o      (ro),
    .illegal_o (illegal)
  );

  csr_value_calc #(.XLEN(XLEN), .IDX_W(IDX_W)) u_calc (
    .kind_i    (kind),
    .is_imm_i  (is_imm),
    .rs1_idx_i (rs1_idx_i),
    .rs1_val_i (rs1_val_i),
    .old_i     (csr_rdata_i),
    .new_o     (new_val)
  );

  logic op_v, rd_v, wr_v, ill_v;
  assign op_v  = instr_valid_i & (kind != CSR_NONE);
  assign rd_v  = instr_valid_i & want_rd;
  assign wr_v  = instr_valid_i & want_wr & ~ro;
  assign ill_v = instr_valid_i & illegal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_op_o  <= 1'b0;
      rd_en_o   <= 1'b0;
      wr_en_o   <= 1'b0;
      rd_fx_o   <= 1'b0;
      wr_fx_o   <= 1'b0;
      illegal_o <= 1'b0;
      wdata_o   <= '0;
      rd_data_o <= '0;
    end else begin
      csr_op_o  <= op_v;
      rd_en_o   <= rd_v;
      wr_en_o   <= wr_v;
      rd_fx_o   <= rd_v & ~ill_v;
      wr_fx_o   <= wr_v;
      illegal_o <= ill_v;
      wdata_o   <= op_v ? new_val : '0;
      rd_data_o <= rd_v ? csr_rdata_i : '0;
    end
  end

  AST_ILLEGAL_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_en_o && !wr_fx_o && !rd_fx_o)); // R9
  AST_RO_NEVER_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && csr_addr_i[ADDR_W-1 -: 2] == 2'b11) |=> !wr_en_o); // R9
  AST_SETCLR_X0_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && funct3_i[1] && rs1_idx_i == '0) |=> (!wr_en_o && !illegal_o)); // R5
  AST_RW_RD0_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && funct3_i[1:0] == 2'b01 && rd_idx_i == '0) |=> (!rd_en_o && !rd_fx_o)); // R8
  AST_SETCLR_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && funct3_i[1]) |=> rd_en_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> (!csr_op_o && !wr_fx_o && !rd_fx_o && !illegal_o)); // R2
endmodule

// File: tb/tb_csr_access_ctl.sv
module tb_csr_access_ctl;
  localparam int XLEN = 16, IDX_W = 5, ADDR_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic              valid;
  logic [2:0]        f3;
  logic [IDX_W-1:0]  rd, rs1;
  logic [XLEN-1:0]   rs1v, old;
  logic [ADDR_W-1:0] addr;
  logic              op_o, rden_o, wren_o, rdfx_o, wrfx_o, ill_o;
  logic [XLEN-1:0]   wd_o, rdd_o;

  csr_access_ctl #(.XLEN(XLEN), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .funct3_i(f3),
    .rd_idx_i(rd), .rs1_idx_i(rs1), .rs1_val_i(rs1v), .csr_addr_i(addr),
    .csr_rdata_i(old), .csr_op_o(op_o), .rd_en_o(rden_o), .wr_en_o(wren_o),
    .rd_fx_o(rdfx_o), .wr_fx_o(wrfx_o), .illegal_o(ill_o),
    .wdata_o(wd_o), .rd_data_o(rdd_o)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic op, rden, wren, rdfx, wrfx, ill;
    logic [XLEN-1:0] wd, rdd;
  } exp_t;

  function automatic exp_t model(logic v, logic [2:0] fn, logic [IDX_W-1:0] d,
      logic [IDX_W-1:0] s, logic [XLEN-1:0] sv, logic [XLEN-1:0] o, logic [ADDR_W-1:0] a);
    exp_t e = '0;
    logic is_op, is_rw, rd_want, wr_want, ro;
    logic [XLEN-1:0] opnd;
    if (!v) return e;
    is_op = (fn != 3'b000) && (fn != 3'b100);
    if (!is_op) return e;
    is_rw = (fn == 3'b001) || (fn == 3'b101);
    opnd = fn[2] ? XLEN'(s) : sv;
    rd_want = is_rw ? (d != 0) : 1'b1;
    wr_want = is_rw ? 1'b1 : (s != 0);
    ro = (a[11:10] == 2'b11);
    e.op = 1'b1;
    e.rden = rd_want;
    e.ill = wr_want && ro;
    e.wren = wr_want && !ro;
    e.wrfx = e.wren;
    e.rdfx = rd_want && !e.ill;
    case (fn[1:0])
      2'b01:   e.wd = opnd;
      2'b10:   e.wd = o | opnd;
      default: e.wd = o & ~opnd;
    endcase
    e.rdd = rd_want ? o : '0;
    return e;
  endfunction

  exp_t ex;

  task automatic apply(logic v, logic [2:0] fn, logic [IDX_W-1:0] d, logic [IDX_W-1:0] s,
      logic [XLEN-1:0] sv, logic [XLEN-1:0] o, logic [ADDR_W-1:0] a);
    @(negedge clk);
    valid = v; f3 = fn; rd = d; rs1 = s; rs1v = sv; old = o; addr = a;
    ex = model(v, fn, d, s, sv, o, a);
    @(negedge clk);  // one register stage
    chk("R1 csr_op", XLEN'(op_o), XLEN'(ex.op));
    chk("R7/R8 rd_en", XLEN'(rden_o), XLEN'(ex.rden));
    chk("R5/R6 wr_en", XLEN'(wren_o), XLEN'(ex.wren));
    chk("R7 rd_fx", XLEN'(rdfx_o), XLEN'(ex.rdfx));
    chk("R11 wr_fx", XLEN'(wrfx_o), XLEN'(ex.wrfx));
    chk("R9 illegal", XLEN'(ill_o), XLEN'(ex.ill));
    chk("R3/R4 wdata", wd_o, ex.wd);
    chk("R10 rd_data", rdd_o, ex.rdd);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    valid = 0; f3 = 0; rd = 0; rs1 = 0; rs1v = 0; old = 0; addr = 0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 reset csr_op", XLEN'(op_o), '0);
    chk("R2 reset wdata", wd_o, '0);
    chk("R2 reset flags", XLEN'({rden_o, wren_o, rdfx_o, wrfx_o, ill_o}), '0);
    rst_n = 1'b1;

    // R2 valid low gives quiet outputs
    apply(1'b0, 3'b001, 5'd3, 5'd4, 16'hffff, 16'h1234, 12'h300);
    // R1 non-CSR funct3 values
    apply(1'b1, 3'b000, 5'd3, 5'd4, 16'hffff, 16'h1234, 12'h300);
    apply(1'b1, 3'b100, 5'd3, 5'd4, 16'hffff, 16'h1234, 12'hc00);
    // R5 set/clear with x0 source, read-only address: no write, no illegal
    apply(1'b1, 3'b010, 5'd1, 5'd0, 16'hffff, 16'h00f0, 12'hc01);
    apply(1'b1, 3'b011, 5'd0, 5'd0, 16'hffff, 16'h00f0, 12'h300);
    // R5 nonzero source holding zero still writes, and is illegal on read-only
    apply(1'b1, 3'b010, 5'd2, 5'd7, 16'h0000, 16'h00f0, 12'h300);
    apply(1'b1, 3'b011, 5'd2, 5'd7, 16'h0000, 16'h00f0, 12'hc02);
    // R6 immediate set/clear with uimm 0
    apply(1'b1, 3'b110, 5'd0, 5'd0, 16'hffff, 16'h5555, 12'hc03);
    apply(1'b1, 3'b111, 5'd9, 5'd0, 16'hffff, 16'h5555, 12'h341);
    // R3 immediate operand zero-extended, rs1 value ignored
    apply(1'b1, 3'b101, 5'd4, 5'd31, 16'hbeef, 16'h5555, 12'h341);
    apply(1'b1, 3'b110, 5'd4, 5'd10, 16'hbeef, 16'h0100, 12'h341);
    // R8 read-write with rd x0, both forms, plus read-only address
    apply(1'b1, 3'b001, 5'd0, 5'd3, 16'ha5a5, 16'h1111, 12'h340);
    apply(1'b1, 3'b101, 5'd0, 5'd3, 16'ha5a5, 16'h1111, 12'h340);
    apply(1'b1, 3'b001, 5'd0, 5'd3, 16'ha5a5, 16'h1111, 12'hf14);
    // R11 set with a mask already present: value unchanged but write strobe fires
    apply(1'b1, 3'b010, 5'd1, 5'd5, 16'h000f, 16'h00ff, 12'h300);
    apply(1'b1, 3'b111, 5'd1, 5'd4, 16'h0000, 16'hff00, 12'h300);
    // R4 clear with full mask
    apply(1'b1, 3'b011, 5'd1, 5'd5, 16'hffff, 16'h1234, 12'h300);

    for (int i = 0; i < 400; i++) begin
      logic [IDX_W-1:0] d, s;
      d = ($urandom_range(0, 3) == 0) ? '0 : IDX_W'($urandom);
      s = ($urandom_range(0, 3) == 0) ? '0 : IDX_W'($urandom);
      apply($urandom_range(0, 7) != 0, 3'($urandom), d, s,
            16'($urandom), 16'($urandom), 12'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule